// File: doc/BRIEF.md
# Channel-Window Conversion Sequencer

This block drives a successive-approximation converter core through a window of analog inputs. Software sets a first and a last channel, picks one-pass or repeating operation, and writes the start command. For each channel the block spends a fixed number of cycles in a sampling phase. It then sends the core a one-cycle launch pulse that carries the channel number, and waits for the core's done pulse and 12-bit result.

Each finished conversion overwrites one shared 16-bit result register with the zero-extended value. It also sets a completion flag that belongs to that channel. A channel whose request-enable bit is set raises a memory-transfer request while its flag is set. The transfer engine's acknowledge clears both the flag and the request. Software can also clear flags by writing ones. A stop command lets the running conversion finish and then returns the block to idle.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, busy, conv_start, done_flags, dma_req and data_out are all 0.
- R2: With first <= last, channels first to last inclusive are converted in ascending order. In one-pass mode (cont_mode = 0) each is converted once, then busy falls.
- R3: With cont_mode = 1, the scan returns to the first channel after the last one and keeps going until it is stopped.
- R4: Once a start is accepted, the block samples for SAMPLE_CYC cycles. conv_start then goes high for exactly one cycle, SAMPLE_CYC cycles after the start edge, with conv_ch set to the channel.
- R5: busy is 1 from the accepted start until the final conversion completes. While a conversion runs, cur_ch shows its channel.
- R6: A conv_done pulse during a conversion writes conv_result, zero-extended, into data_out, replacing the previous value. It also sets done_flags bit [channel].
- R7: start_wr is accepted only when trig_sel == 0 (software trigger). With any other value, start_wr has no effect.
- R8: dma_req[i] is 1 exactly while done_flags[i] and dma_en[i] are both 1. It stays high until a dma_ack[i] pulse, which clears done_flags[i] and therefore dma_req[i].
- R9: Writing 1 to flag_clr[i] clears done_flags[i] on the next cycle.
- R10: stop_wr during a scan lets the conversion in progress complete. No further conv_start follows, and busy falls.
- R11: With first > last, only the first channel is converted: once in one-pass mode, repeatedly in continuous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_wr | input | 1 | Start command pulse |
| stop_wr | input | 1 | Stop command pulse |
| cont_mode | input | 1 | 1 = continuous scan, 0 = one pass |
| ch_first | input | 3 | First channel of the window |
| ch_last | input | 3 | Last channel of the window |
| trig_sel | input | 2 | Trigger source, 0 = software |
| dma_en | input | 8 | Per-channel transfer-request enable |
| flag_clr | input | 8 | Write-1-to-clear for completion flags |
| dma_ack | input | 8 | Per-channel transfer acknowledge pulse |
| busy | output | 1 | Scan in progress |
| cur_ch | output | 3 | Channel being converted |
| data_out | output | 16 | Latest result, zero-extended |
| done_flags | output | 8 | Per-channel completion flags |
| dma_req | output | 8 | Per-channel transfer requests |
| conv_start | output | 1 | Launch pulse to the converter core |
| conv_ch | output | 3 | Channel for the launch |
| conv_done | input | 1 | Completion pulse from the core |
| conv_result | input | 12 | Result from the core |

## Verification
The hardest case to reach is a stop that arrives while a continuous scan is partway through a conversion, after the window has already wrapped. The bench runs a converter model that counts launches and checks each one against a computed channel sequence. It issues the stop only after the fifth launch of a two-channel continuous window, and then confirms that no sixth launch ever appears. A sweep over all 64 first/last pairs covers both the ascending window and the reversed window.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_LAUNCH = 2'd2,
        ST_WAIT   = 2'd3
    } scan_st_e;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int CH_W       = 3,
    parameter int TRIG_W     = 2,
    parameter int SAMPLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              stop_wr,
    input  logic              cont_mode,
    input  logic [CH_W-1:0]   ch_first,
    input  logic [CH_W-1:0]   ch_last,
    input  logic [TRIG_W-1:0] trig_sel,
    input  logic              conv_done,
    output logic              busy,
    output logic [CH_W-1:0]   cur_ch,
    output logic              conv_start,
    output logic              cmpl,
    output logic [CH_W-1:0]   cmpl_ch
);
    localparam int CNT_W = $clog2(SAMPLE_CYC + 1);

    typedef struct packed {
        scan_st_e        st;
        logic [CNT_W-1:0] cnt;
        logic [CH_W-1:0] ch;
        logic [CH_W-1:0] first;
        logic [CH_W-1:0] last;
        logic            cont;
        logic            stop_pend;
    } ctrl_s;

    ctrl_s r_q, r_d;
    logic  at_end, stop_now;

    always_comb begin
        r_d      = r_q;
        at_end   = (r_q.ch >= r_q.last);
        stop_now = r_q.stop_pend | stop_wr;
        if (stop_wr && r_q.st != ST_IDLE) r_d.stop_pend = 1'b1;
        case (r_q.st)
            ST_IDLE: begin
                if (start_wr && trig_sel == '0) begin
                    r_d.st        = ST_SAMPLE;
                    r_d.cnt       = '0;
                    r_d.ch        = ch_first;
                    r_d.first     = ch_first;
                    r_d.last      = ch_last;
                    r_d.cont      = cont_mode;
                    r_d.stop_pend = 1'b0;
                end
            end
            ST_SAMPLE: begin
                if (r_q.cnt == CNT_W'(SAMPLE_CYC - 1)) r_d.st = ST_LAUNCH;
                else r_d.cnt = r_q.cnt + 1'b1;
            end
            ST_LAUNCH: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (conv_done) begin
                    if (stop_now || (at_end && !r_q.cont)) begin
                        r_d.st        = ST_IDLE;
                        r_d.stop_pend = 1'b0;
                    end else begin
                        r_d.st  = ST_SAMPLE;
                        r_d.cnt = '0;
                        r_d.ch  = at_end ? r_q.first : r_q.ch + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign cur_ch     = r_q.ch;
    assign conv_start = (r_q.st == ST_LAUNCH);
    assign cmpl       = (r_q.st == ST_WAIT) && conv_done;
    assign cmpl_ch    = r_q.ch;

    // R2 / R11: the active channel never leaves the latched window
    a_r2_ch_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((r_q.first <= r_q.last) ? (r_q.ch >= r_q.first && r_q.ch <= r_q.last)
                                          : (r_q.ch == r_q.first)));
    // R4: launch lasts one cycle and follows a sampling phase
    a_r4_single_launch: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    a_r4_sample_before: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(r_q.st == ST_SAMPLE));
    // R10: a pending stop ends the scan at the next completion
    a_r10_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl && r_q.stop_pend) |=> !busy);
endmodule

// File: rtl/result_flags.sv
module result_flags #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3,
    parameter int RES_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmpl,
    input  logic [CH_W-1:0]   cmpl_ch,
    input  logic [RES_W-1:0]  conv_result,
    input  logic [NUM_CH-1:0] dma_en,
    input  logic [NUM_CH-1:0] flag_clr,
    input  logic [NUM_CH-1:0] dma_ack,
    output logic [DATA_W-1:0] data_out,
    output logic [NUM_CH-1:0] done_flags,
    output logic [NUM_CH-1:0] dma_req
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [NUM_CH-1:0] flags;
    } res_s;

    res_s              r_q, r_d;
    logic [NUM_CH-1:0] set_vec;

    always_comb begin
        r_d     = r_q;
        set_vec = '0;
        if (cmpl) begin
            set_vec[cmpl_ch] = 1'b1;
            r_d.data         = DATA_W'(conv_result);
        end
        r_d.flags = (r_q.flags & ~flag_clr & ~dma_ack) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign data_out   = r_q.data;
    assign done_flags = r_q.flags;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_req
        assign dma_req[i] = r_q.flags[i] & dma_en[i];
    end

    // R6: a completion leaves its channel flag set
    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl |=> ((done_flags & $past(set_vec)) == $past(set_vec)));
    // R8: acknowledge clears flag and request
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dma_ack & ~set_vec)) |=> ((dma_req & $past(dma_ack & ~set_vec)) == '0));
    // R9: write-1-to-clear takes effect
    a_r9_clr_works: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_clr & ~set_vec)) |=> ((done_flags & $past(flag_clr & ~set_vec)) == '0));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
    parameter int NUM_CH     = 8,
    parameter int RES_W      = 12,
    parameter int DATA_W     = 16,
    parameter int TRIG_W     = 2,
    parameter int SAMPLE_CYC = 4,
    localparam int CH_W      = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              stop_wr,
    input  logic              cont_mode,
    input  logic [CH_W-1:0]   ch_first,
    input  logic [CH_W-1:0]   ch_last,
    input  logic [TRIG_W-1:0] trig_sel,
    input  logic [NUM_CH-1:0] dma_en,
    input  logic [NUM_CH-1:0] flag_clr,
    input  logic [NUM_CH-1:0] dma_ack,
    output logic              busy,
    output logic [CH_W-1:0]   cur_ch,
    output logic [DATA_W-1:0] data_out,
    output logic [NUM_CH-1:0] done_flags,
    output logic [NUM_CH-1:0] dma_req,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_ch,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result
);
    logic            cmpl;
    logic [CH_W-1:0] cmpl_ch;

    scan_ctrl #(.CH_W(CH_W), .TRIG_W(TRIG_W), .SAMPLE_CYC(SAMPLE_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .stop_wr(stop_wr),
        .cont_mode(cont_mode), .ch_first(ch_first), .ch_last(ch_last),
        .trig_sel(trig_sel), .conv_done(conv_done), .busy(busy), .cur_ch(cur_ch),
        .conv_start(conv_start), .cmpl(cmpl), .cmpl_ch(cmpl_ch)
    );

    result_flags #(.NUM_CH(NUM_CH), .CH_W(CH_W), .RES_W(RES_W), .DATA_W(DATA_W)) u_res (
        .clk(clk), .rst_n(rst_n), .cmpl(cmpl), .cmpl_ch(cmpl_ch),
        .conv_result(conv_result), .dma_en(dma_en), .flag_clr(flag_clr),
        .dma_ack(dma_ack), .data_out(data_out), .done_flags(done_flags),
        .dma_req(dma_req)
    );

    assign conv_ch = cur_ch;

    // R5: a launch only happens inside a busy scan
    a_r5_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);
    // R7: a non-software trigger never starts a scan from idle
    a_r7_trig_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (trig_sel != '0)) |=> !busy);
endmodule

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
    localparam int SC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_wr = 0, stop_wr = 0, cont_mode = 0;
    logic [2:0]  ch_first = 0, ch_last = 0;
    logic [1:0]  trig_sel = 0;
    logic [7:0]  dma_en = 0, flag_clr = 0, dma_ack = 0;
    logic        busy, conv_start, conv_done;
    logic [2:0]  cur_ch, conv_ch;
    logic [15:0] data_out;
    logic [7:0]  done_flags, dma_req;
    logic [11:0] conv_result;

    int checks = 0, errors = 0;
    int exp_seq[0:255];
    int exp_len = 0, seen = 0;
    logic [8:0]  run_cnt = 0;
    logic [11:0] last_res = 0;

    always #4 clk = ~clk;

    adc_scan_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .stop_wr(stop_wr),
        .cont_mode(cont_mode), .ch_first(ch_first), .ch_last(ch_last),
        .trig_sel(trig_sel), .dma_en(dma_en), .flag_clr(flag_clr), .dma_ack(dma_ack),
        .busy(busy), .cur_ch(cur_ch), .data_out(data_out), .done_flags(done_flags),
        .dma_req(dma_req), .conv_start(conv_start), .conv_ch(conv_ch),
        .conv_done(conv_done), .conv_result(conv_result)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // converter core model: checks every launch against the expected sequence
    initial begin
        conv_done = 0;
        conv_result = 0;
        forever begin
            @(negedge clk);
            if (conv_start) begin
                automatic int c = int'(conv_ch);
                automatic int e = (seen < exp_len) ? exp_seq[seen] : -1;
                automatic logic [11:0] res = {conv_ch, run_cnt};
                chk(c == e, "R2 channel order", c, e);
                chk(busy && int'(cur_ch) == c, "R5 busy/cur_ch", int'(cur_ch), c);
                seen++;
                repeat (2) @(negedge clk);
                conv_result = res;
                conv_done = 1;
                @(negedge clk);
                conv_done = 0;
                chk(data_out == {4'h0, res}, "R6 data", int'(data_out), int'(res));
                chk(done_flags[c] == 1'b1, "R6 flag", int'(done_flags), c);
                last_res = res;
                run_cnt++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    task automatic pulse_start();
        @(negedge clk) start_wr = 1;
        @(negedge clk) start_wr = 0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk) flag_clr = 8'hFF;
        @(negedge clk) flag_clr = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && conv_start == 0, "R1 busy/start", int'(busy), 0);
        chk(done_flags == 0 && dma_req == 0, "R1 flags/req", int'(done_flags), 0);
        chk(data_out == 0, "R1 data", int'(data_out), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R4 timing of the launch pulse
        ch_first = 1; ch_last = 1; cont_mode = 0;
        exp_seq[0] = 1; exp_len = 1; seen = 0;
        pulse_start();
        chk(busy == 1, "R5 busy after start", int'(busy), 1);
        repeat (SC - 1) @(negedge clk);
        chk(conv_start == 0, "R4 sampling phase", int'(conv_start), 0);
        @(negedge clk);
        chk(conv_start == 1 && conv_ch == 3'd1, "R4 launch", int'(conv_start), 1);
        @(negedge clk);
        chk(conv_start == 0, "R4 one-cycle pulse", int'(conv_start), 0);
        wait_idle();
        clear_all();

        // R2 / R11 sweep over every window in one-pass mode
        for (int f = 0; f < 8; f++) begin
            for (int l = 0; l < 8; l++) begin
                automatic int mask = 0;
                exp_len = 0;
                if (f <= l) begin
                    for (int c = f; c <= l; c++) begin
                        exp_seq[exp_len] = c; exp_len++; mask |= (1 << c);
                    end
                end else begin
                    exp_seq[0] = f; exp_len = 1; mask = 1 << f;
                end
                seen = 0;
                ch_first = 3'(f); ch_last = 3'(l); cont_mode = 0;
                pulse_start();
                wait_idle();
                chk(seen == exp_len, (f > l) ? "R11 reversed count" : "R2 count", seen, exp_len);
                chk(int'(done_flags) == mask, "R6 flag mask", int'(done_flags), mask);
                chk(data_out == {4'h0, last_res}, "R6 last result kept", int'(data_out), int'(last_res));
                clear_all();
                chk(done_flags == 0, "R9 w1c", int'(done_flags), 0);
            end
        end

        // R3 / R10 continuous window 3..4, stop after five launches
        for (int k = 0; k < 256; k++) exp_seq[k] = 3 + (k % 2);
        exp_len = 256; seen = 0;
        ch_first = 3; ch_last = 4; cont_mode = 1;
        pulse_start();
        for (int k = 0; k < 2000 && seen < 5; k++) @(negedge clk);
        chk(seen == 5, "R3 wraps past window", seen, 5);
        @(negedge clk) stop_wr = 1;
        @(negedge clk) stop_wr = 0;
        chk(busy == 1, "R10 conversion still running", int'(busy), 1);
        wait_idle();
        repeat (30) @(negedge clk);
        chk(seen == 5 && busy == 0, "R10 no launch after stop", seen, 5);
        chk(data_out == {4'h0, last_res} && last_res[11:9] == 3'd3, "R10 last finished", int'(data_out), int'(last_res));
        clear_all();

        // R11 continuous reversed window repeats the first channel
        for (int k = 0; k < 256; k++) exp_seq[k] = 6;
        seen = 0;
        ch_first = 6; ch_last = 2; cont_mode = 1;
        pulse_start();
        for (int k = 0; k < 2000 && seen < 3; k++) @(negedge clk);
        @(negedge clk) stop_wr = 1;
        @(negedge clk) stop_wr = 0;
        wait_idle();
        chk(seen == 3, "R11 continuous reversed", seen, 3);
        clear_all();

        // R7 non-software trigger ignored
        exp_len = 0; seen = 0; cont_mode = 0; ch_first = 0; ch_last = 7;
        for (int t = 1; t < 4; t++) begin
            trig_sel = 2'(t);
            pulse_start();
            repeat (20) @(negedge clk);
            chk(busy == 0 && seen == 0, "R7 trigger gated", int'(busy), 0);
        end
        trig_sel = 0;

        // R8 request held until acknowledge
        dma_en = 8'h20;
        exp_seq[0] = 5; exp_len = 1; seen = 0; ch_first = 5; ch_last = 5;
        pulse_start();
        wait_idle();
        chk(dma_req == 8'h20, "R8 request raised", int'(dma_req), 32);
        repeat (10) @(negedge clk);
        chk(dma_req == 8'h20, "R8 request held", int'(dma_req), 32);
        @(negedge clk) dma_ack = 8'h20;
        @(negedge clk) dma_ack = 8'h00;
        chk(dma_req == 0 && done_flags == 0, "R8 ack clears", int'(done_flags), 0);

        // R8 disabled channel: flag without request; R9 clears it
        exp_seq[0] = 6; exp_len = 1; seen = 0; ch_first = 6; ch_last = 6;
        pulse_start();
        wait_idle();
        chk(done_flags == 8'h40 && dma_req == 0, "R8 enable gates", int'(dma_req), 0);
        @(negedge clk) flag_clr = 8'h40;
        @(negedge clk) flag_clr = 8'h00;
        chk(done_flags == 0, "R9 single clear", int'(done_flags), 0);

        summary();
    end
endmodule